// File: doc/BRIEF.md
# Masked Interrupt Flag Collector

This block gathers single-cycle event pulses from several interrupt sources. Each pulse sets a sticky flag bit. A per-source enable register masks each flag. When at least one flag is both set and enabled, the block pulls a shared, active-low interrupt line low. The line is modelled as an output-enable plus a data value that is always zero. When nothing enabled is pending, the block releases the line to high impedance so that an external pull-up, and other devices on the same wire, can set its level.

The host reads the status with a one-cycle read strobe. On the next cycle the block returns the flags and a summary bit, marked by a one-cycle valid pulse. That same read clears the flags, which in turn releases the line. The read data port has no ready signal. The host cannot stall it, so the result must be taken in the cycle `rd_valid` is high. `rd_data` keeps its value until the next read.

A separate flag-clear input wipes all pending flags but keeps the enable bits. The system reset `rst_n` clears everything.

Top module: `irq_flag_collector`

## Requirements
- R1: An event pulse on `evt[i]` sets flag i on the next clock edge. Flag i then stays set until it is cleared. Source index 0 is periodic, 1 is alarm and 2 is update-ended.
- R2: `irq_oe` is 1 exactly while some flag i is set and enable bit i is 1. `irq_dat` is always 0, so the line is driven low only while requested and is high impedance otherwise.
- R3: A flag whose enable bit is 0 still latches its event. It does not raise `irq_oe`, and it does not set the summary bit.
- R4: A read strobe `rd_stb` at one edge gives `rd_valid`=1 for exactly the next cycle. In that cycle `rd_data[NUM_SRC-1:0]` holds the flags as they were before the read. `rd_data[NUM_SRC]` is the summary bit: 1 when any enabled flag was set.
- R5: A read clears every flag that has no new event in the same cycle, so `irq_oe` falls after the read edge.
- R6: An event that arrives in the same cycle as a read leaves its flag set afterwards. That flag is not part of the data returned by this read.
- R7: `flag_clr`=1 clears all flags at the next edge, even those whose event arrives in that cycle. The enable register is not changed.
- R8: `en_we`=1 loads `en_wdata` into the enable register at the edge. `rst_n`=0 clears the flags, the enables, `rd_data` and `rd_valid`.
- R9: `rd_data` holds its value between reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous system reset |
| evt | input | NUM_SRC | Event pulses, one per source |
| flag_clr | input | 1 | Clears all flags, keeps enables |
| en_we | input | 1 | Enable register write strobe |
| en_wdata | input | NUM_SRC | New enable bits |
| rd_stb | input | 1 | One-cycle host read strobe |
| rd_valid | output | 1 | Read data valid, one cycle after strobe |
| rd_data | output | NUM_SRC+1 | Summary bit on top, flags below |
| irq_oe | output | 1 | Interrupt line output-enable (line pulled low when 1) |
| irq_dat | output | 1 | Interrupt line data value, constant 0 |

## Verification
The bench builds the block with the default of three sources. At that size every flag position can be checked on its own, and the summary bit sits at bit 3. This reaches the cases where one source is masked while another is not, and where an event collides with a read or with a flag clear. The bench also checks that a flag clear leaves a previously written enable pattern in place, which it sees through `irq_oe` on later events.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;
  localparam int SRC_PERIODIC = 0;
  localparam int SRC_ALARM    = 1;
  localparam int SRC_UPDATE   = 2;
  localparam int DEF_NUM_SRC  = 3;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int NUM_SRC = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] evt,
  input  logic               flag_clr,
  input  logic               rd_stb,
  output logic [NUM_SRC-1:0] flags
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n || flag_clr)
        flags[i] <= 1'b0;
      else if (evt[i])
        flags[i] <= 1'b1;
      else if (rd_stb)
        flags[i] <= 1'b0;
    end

    assert_evt_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (evt[i] && !flag_clr) |=> flags[i]);
    assert_evt_survives_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (evt[i] && rd_stb && !flag_clr) |=> flags[i]);
    assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && !evt[i]) |=> !flags[i]);
  end

  assert_flag_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr |=> (flags == '0));
endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg #(
  parameter int NUM_SRC = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_we,
  input  logic [NUM_SRC-1:0] en_wdata,
  input  logic               flag_clr,
  output logic [NUM_SRC-1:0] en
);
  always_ff @(posedge clk) begin
    if (!rst_n)     en <= '0;
    else if (en_we) en <= en_wdata;
  end

  assert_en_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !en_we) |=> $stable(en));
  assert_en_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    en_we |=> (en == $past(en_wdata)));
endmodule

// File: rtl/irq_line_drv.sv
module irq_line_drv #(
  parameter int NUM_SRC = 3
) (
  input  logic [NUM_SRC-1:0] flags,
  input  logic [NUM_SRC-1:0] en,
  output logic               pending,
  output logic               irq_oe,
  output logic               irq_dat
);
  always_comb begin
    pending = |(flags & en);
    irq_oe  = pending;
    irq_dat = 1'b0;
  end
endmodule

// File: rtl/irq_read_port.sv
module irq_read_port #(
  parameter int NUM_SRC = 3,
  localparam int RD_W = NUM_SRC + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_stb,
  input  logic [NUM_SRC-1:0] flags,
  input  logic               pending,
  output logic               rd_valid,
  output logic [RD_W-1:0]    rd_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_stb;
      if (rd_stb) rd_data <= {pending, flags};
    end
  end

  assert_valid_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> rd_valid);
  assert_no_spurious_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> !rd_valid);
  assert_data_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_stb && $past(rst_n)) |=> $stable(rd_data));
endmodule

// File: rtl/irq_flag_collector.sv
module irq_flag_collector
  import irq_flag_pkg::*;
#(
  parameter int NUM_SRC = DEF_NUM_SRC,
  localparam int RD_W = NUM_SRC + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] evt,
  input  logic               flag_clr,
  input  logic               en_we,
  input  logic [NUM_SRC-1:0] en_wdata,
  input  logic               rd_stb,
  output logic               rd_valid,
  output logic [RD_W-1:0]    rd_data,
  output logic               irq_oe,
  output logic               irq_dat
);
  logic [NUM_SRC-1:0] flags;
  logic [NUM_SRC-1:0] en;
  logic               pending;

  irq_flag_bank #(.NUM_SRC(NUM_SRC)) u_bank (
    .clk(clk), .rst_n(rst_n), .evt(evt), .flag_clr(flag_clr),
    .rd_stb(rd_stb), .flags(flags)
  );

  irq_enable_reg #(.NUM_SRC(NUM_SRC)) u_en (
    .clk(clk), .rst_n(rst_n), .en_we(en_we), .en_wdata(en_wdata),
    .flag_clr(flag_clr), .en(en)
  );

  irq_line_drv #(.NUM_SRC(NUM_SRC)) u_drv (
    .flags(flags), .en(en), .pending(pending),
    .irq_oe(irq_oe), .irq_dat(irq_dat)
  );

  irq_read_port #(.NUM_SRC(NUM_SRC)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .flags(flags),
    .pending(pending), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  assert_release_after_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !flag_clr && evt == '0) |=> !irq_oe);
  assert_release_after_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr |=> !irq_oe);
  assert_line_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_oe |-> (irq_dat == 1'b0));
endmodule

// File: tb/tb_irq_flag_collector.sv
module tb_irq_flag_collector;
  localparam int CLK_PERIOD = 10;
  localparam int N = 3;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] evt = '0, en_wdata = '0;
  logic flag_clr = 0, en_we = 0, rd_stb = 0;
  logic rd_valid, irq_oe, irq_dat;
  logic [N:0] rd_data;
  int checks = 0, errors = 0;
  bit done = 0;

  irq_flag_collector #(.NUM_SRC(N)) dut (
    .clk(clk), .rst_n(rst_n), .evt(evt), .flag_clr(flag_clr),
    .en_we(en_we), .en_wdata(en_wdata), .rd_stb(rd_stb),
    .rd_valid(rd_valid), .rd_data(rd_data), .irq_oe(irq_oe), .irq_dat(irq_dat)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(); @(negedge clk); endtask

  task automatic write_en(logic [N-1:0] v);
    en_we = 1; en_wdata = v; cyc(); en_we = 0;
  endtask

  task automatic pulse(logic [N-1:0] m);
    evt = m; cyc(); evt = '0;
  endtask

  // read: strobe for one edge, sample in the following cycle
  task automatic do_read(string req, logic [N:0] exp);
    rd_stb = 1; cyc(); rd_stb = 0;
    chk({req, " valid"}, rd_valid, 1);
    chk({req, " data"}, rd_data, exp);
    cyc();
    chk({req, " valid drop"}, rd_valid, 0);
  endtask

  task automatic t_reset();
    rst_n = 0; cyc(); cyc(); rst_n = 1; cyc();
    chk("R8 reset oe", irq_oe, 0);
    chk("R8 reset valid", rd_valid, 0);
    chk("R8 reset data", rd_data, 0);
    chk("R2 dat low", irq_dat, 0);
  endtask

  task automatic t_set_and_read();
    write_en(3'b111);
    pulse(3'b010);                       // alarm
    chk("R1 R2 oe after alarm", irq_oe, 1);
    chk("R2 dat low", irq_dat, 0);
    do_read("R4 R1 alarm read", 4'b1010);
    chk("R5 oe released", irq_oe, 0);
    do_read("R5 flags cleared", 4'b0000);
    pulse(3'b101);
    do_read("R1 periodic+update", 4'b1101);
  endtask

  task automatic t_masked();
    write_en(3'b001);
    pulse(3'b100);
    chk("R3 masked no oe", irq_oe, 0);
    do_read("R3 masked flag, no summary", 4'b0100);
    pulse(3'b001);
    chk("R2 enabled periodic oe", irq_oe, 1);
    do_read("R2 periodic read", 4'b1001);
  endtask

  task automatic t_collide();
    write_en(3'b111);
    pulse(3'b001);
    evt = 3'b010; rd_stb = 1; cyc(); evt = '0; rd_stb = 0;
    chk("R6 collide data", rd_data, 4'b1001);
    chk("R6 oe kept", irq_oe, 1);
    cyc();
    do_read("R6 kept alarm", 4'b1010);
  endtask

  task automatic t_flag_clr();
    write_en(3'b010);
    pulse(3'b111);
    chk("R7 pre oe", irq_oe, 1);
    evt = 3'b001; flag_clr = 1; cyc(); evt = '0; flag_clr = 0;
    chk("R7 oe off", irq_oe, 0);
    do_read("R7 all cleared", 4'b0000);
    pulse(3'b001);
    chk("R7 enables kept (masked)", irq_oe, 0);
    pulse(3'b010);
    chk("R7 enables kept (alarm)", irq_oe, 1);
    do_read("R7 read", 4'b1011);
  endtask

  task automatic t_hold();
    write_en(3'b111);
    pulse(3'b100);
    do_read("R9 base", 4'b1100);
    pulse(3'b001);
    cyc(); cyc();
    chk("R9 data held", rd_data, 4'b1100);
    do_read("R9 new", 4'b1001);
  endtask

  initial begin
    cyc();
    t_reset();
    t_set_and_read();
    t_masked();
    t_collide();
    t_flag_clr();
    t_hold();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule